// File: doc/BRIEF.md
# Randomized Retransmission Backoff Scheduler

This block decides how long a transmitter defers before each attempt to send a frame, and then counts that deferral down. The caller presents the frame's current retry mask and pulses `start_i`. The block widens the mask by one bit: it shifts the mask left and sets bit 0. If the widened mask reaches the top bit, the frame is abandoned and a fixed error code is raised. Otherwise the block derives a wait in slot times and counts it down on a base tick strobe. When the count runs out it pulses `go_o` to enable output.

On the first attempt the widened mask equals 1, and the wait is a fixed 20 slots, about 1 ms. On later attempts the slot count is a free-running random value, XORed with the channel number, then limited by the previous mask. Each slot is eight base ticks. The countdown mimics a short hardware timer. A 6-bit low part is loaded first. Then a high part is decremented once per timer expiry, with a 64-tick reload each time, until it would go negative.

An abort cancels the wait. The timer segment already in flight still runs out. Its expiry is then ignored, and it is recorded in a sticky flag.

Top module: `bkoff_sched`

## Requirements
- R1: After synchronous active-low reset, `go_o`, `busy_o`, `mask_vld_o`, `err_o`, `spurious_o` are 0, and `mask_o` and `err_code_o` are 0.
- R2: A start accepted at a clock edge (while `busy_o` is 0 and `abort_i` is 0) gives, in the next cycle, a one-cycle `mask_vld_o` pulse with `mask_o` = (`mask_i` << 1) | 1, truncated to 16 bits. `mask_o` holds that value until the next accepted start.
- R3: If bit 15 of the updated mask is set, `err_o` pulses for one cycle with `err_code_o` = 0x6400. No wait starts and `go_o` stays 0. `err_code_o` is 0 whenever `err_o` is 0.
- R4: If the updated mask equals 1 (this includes an input mask of 0x8000), the wait is 20 slots, which is 160 ticks.
- R5: Otherwise the wait in slots is (`rand_i` XOR zero-extended `chan_i`) AND bits 10..1 of the updated mask. `busy_o` is 1 during the wait. `go_o` pulses for one cycle right after the edge that samples the last tick of 8×slots ticks.
- R6: A wait of zero slots pulses `go_o` in the cycle right after the start edge, with `busy_o` staying 0.
- R7: Only cycles with `tick_i` high advance the wait, so the tick count to `go_o` is independent of tick spacing.
- R8: `start_i` during a wait is ignored: no `mask_vld_o`, `mask_o` unchanged, and the original wait completes on time.
- R9: `abort_i` sampled at an edge makes `busy_o` 0 in the next cycle, and that attempt never pulses `go_o`. An abort in the same cycle as a start makes the start ignored.
- R10: After an abort, the timer segment in flight (at most 64 ticks) still expires. That expiry produces no `go_o` and sets `spurious_o`, which stays 1 until reset.
- R11: Waits longer than one 64-tick timer segment are exact up to the largest wait of 1023 slots (8184 ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an attempt (one-cycle strobe) |
| mask_i | input | 16 | Frame's retry mask before this attempt |
| rand_i | input | 10 | Free-running random value |
| chan_i | input | 4 | Channel number mixed into the random value |
| tick_i | input | 1 | Base tick strobe, one cycle wide |
| abort_i | input | 1 | Synchronous cancel of the wait |
| go_o | output | 1 | Output enable pulse at the end of the wait |
| busy_o | output | 1 | A wait is armed |
| mask_vld_o | output | 1 | Pulse: `mask_o` was updated |
| mask_o | output | 16 | Updated retry mask |
| err_o | output | 1 | Pulse: retry count overflow |
| err_code_o | output | 16 | Completion code, 0x6400 during `err_o` |
| spurious_o | output | 1 | Sticky: timer expiry seen with no wait armed |

## Verification
A corrupted segment count or a wrong reload shows as `go_o` arriving a whole multiple of 64 ticks early or late. A wrong low segment or slot arithmetic shifts `go_o` by a multiple of 8 ticks. Either error is visible at the end of the very next wait. The bench therefore counts delivered ticks up to `go_o` and compares the count with 8×slots, over every mask width and several random and channel values. A stuck state after abort shows within 64 ticks, either as a stray `go_o` or as a missing `spurious_o`.

// File: rtl/bkoff_pkg.sv
// Package: shared state type for the backoff scheduler.
package bkoff_pkg;
    // Sequencer state: idle, or waiting on the timer.
    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_WAIT = 1'b1
    } bk_state_t;
endpackage

// File: rtl/bkoff_calc.sv
// bkoff_calc: combinational attempt arithmetic.
// Widens the retry mask, flags overflow and computes the wait in base ticks.
// Assumes MASK_W > RAND_W and CHAN_W <= RAND_W.
module bkoff_calc #(
    parameter int MASK_W      = 16,
    parameter int RAND_W      = 10,
    parameter int CHAN_W      = 4,
    parameter int SLOT_LG     = 3,
    parameter int FIRST_SLOTS = 20,
    localparam int TICK_W     = RAND_W + SLOT_LG
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [RAND_W-1:0] rand_i,
    input  logic [CHAN_W-1:0] chan_i,
    output logic [MASK_W-1:0] upd_o,
    output logic              ovf_o,
    output logic [TICK_W-1:0] ticks_o
);
    logic              first;
    logic [RAND_W-1:0] mixed;
    logic [RAND_W-1:0] slots;

    // Mask growth, overflow test and slot selection.
    always_comb begin
        upd_o   = (mask_i << 1) | MASK_W'(1);
        ovf_o   = upd_o[MASK_W-1];
        first   = (upd_o == MASK_W'(1));
        mixed   = rand_i ^ RAND_W'(chan_i);
        slots   = first ? RAND_W'(FIRST_SLOTS) : (mixed & upd_o[RAND_W:1]);
        ticks_o = {slots, {SLOT_LG{1'b0}}};
    end
endmodule

// File: rtl/bkoff_timer.sv
// bkoff_timer: short down-counting timer on the base tick strobe.
// A load arms it with 1..2**LO_W ticks. The expiry strobe is combinational
// and fires on the tick that empties it, so the sequencer can reload it in
// the same cycle without losing a tick. A load outranks the expiry.
module bkoff_timer #(
    parameter int LO_W = 6,
    localparam int CNT_W = LO_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Expiry on the last tick of an armed count.
    assign expire_o = armed_q && tick_i && (cnt_q == CNT_W'(1));

    // Count register: load, disarm on expiry, or decrement on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (ld_i) begin
            cnt_q   <= ld_val_i;
            armed_q <= 1'b1;
        end else if (expire_o) begin
            armed_q <= 1'b0;
        end else if (armed_q && tick_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/bkoff_seq.sv
// bkoff_seq: attempt sequencer.
// Accepts a start when idle and registers the updated mask. It then raises
// an error, fires at once, or arms the timer with the low segment and keeps
// the high segment, which it decrements per expiry until it goes negative.
// Assumes a nonzero wait is a multiple of 8 ticks and fits TICK_W bits.
module bkoff_seq
    import bkoff_pkg::*;
#(
    parameter int MASK_W = 16,
    parameter int TICK_W = 13,
    parameter int LO_W   = 6,
    localparam int HI_W  = TICK_W - LO_W,
    localparam int HC_W  = HI_W + 1,
    localparam int CNT_W = LO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              ovf_i,
    input  logic [MASK_W-1:0] upd_i,
    input  logic [TICK_W-1:0] ticks_i,
    input  logic              expire_i,
    output logic              ld_o,
    output logic [CNT_W-1:0]  ld_val_o,
    output logic              go_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              mask_vld_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              spurious_o
);
    localparam logic [CNT_W-1:0] SEG = CNT_W'(1) << LO_W;

    bk_state_t         state_q;
    logic [HC_W-1:0]   hi_cnt_q;
    logic [HC_W-1:0]   hi_dec;
    logic [LO_W-1:0]   lo;
    logic [HI_W-1:0]   hi;
    logic              accept;
    logic              zero_wait;
    logic              lo_zero;
    logic              go_q, err_q, vld_q, spur_q;
    logic [MASK_W-1:0] mask_q;

    // Decode of the new attempt and of the high-segment step.
    always_comb begin
        lo        = ticks_i[LO_W-1:0];
        hi        = ticks_i[TICK_W-1:LO_W];
        lo_zero   = (lo == '0);
        zero_wait = (ticks_i == '0);
        accept    = start_i && !abort_i && (state_q == BK_IDLE);
        hi_dec    = hi_cnt_q - HC_W'(1);
    end

    // Timer load requests: first segment on start, full segment on reload.
    always_comb begin
        ld_o     = 1'b0;
        ld_val_o = SEG;
        if (accept && !ovf_i && !zero_wait) begin
            ld_o     = 1'b1;
            ld_val_o = lo_zero ? SEG : {1'b0, lo};
        end else if ((state_q == BK_WAIT) && !abort_i && expire_i && !hi_dec[HC_W-1]) begin
            ld_o     = 1'b1;
            ld_val_o = SEG;
        end
    end

    // State, high segment counter and registered result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BK_IDLE;
            hi_cnt_q <= '0;
            go_q     <= 1'b0;
            err_q    <= 1'b0;
            vld_q    <= 1'b0;
            spur_q   <= 1'b0;
            mask_q   <= '0;
        end else begin
            go_q  <= 1'b0;
            err_q <= 1'b0;
            vld_q <= 1'b0;
            if (abort_i) begin
                state_q <= BK_IDLE;
            end else begin
                case (state_q)
                    BK_IDLE: begin
                        if (expire_i) begin
                            spur_q <= 1'b1;
                        end
                        if (accept) begin
                            vld_q  <= 1'b1;
                            mask_q <= upd_i;
                            if (ovf_i) begin
                                err_q <= 1'b1;
                            end else if (zero_wait) begin
                                go_q <= 1'b1;
                            end else begin
                                state_q  <= BK_WAIT;
                                hi_cnt_q <= lo_zero ? ({1'b0, hi} - HC_W'(1)) : {1'b0, hi};
                            end
                        end
                    end
                    BK_WAIT: begin
                        if (expire_i) begin
                            if (hi_dec[HC_W-1]) begin
                                go_q    <= 1'b1;
                                state_q <= BK_IDLE;
                            end else begin
                                hi_cnt_q <= hi_dec;
                            end
                        end
                    end
                    default: state_q <= BK_IDLE;
                endcase
            end
        end
    end

    assign go_o       = go_q;
    assign err_o      = err_q;
    assign mask_vld_o = vld_q;
    assign mask_o     = mask_q;
    assign spurious_o = spur_q;
    assign busy_o     = (state_q == BK_WAIT);
endmodule

// File: rtl/bkoff_sched.sv
// bkoff_sched: retransmission backoff scheduler top.
// Wires the attempt arithmetic, the sequencer and the segment timer.
// Assumes tick_i is a one-cycle strobe and start_i a one-cycle strobe.
module bkoff_sched #(
    parameter int MASK_W      = 16,
    parameter int RAND_W      = 10,
    parameter int CHAN_W      = 4,
    parameter int SLOT_LG     = 3,
    parameter int LO_W        = 6,
    parameter int FIRST_SLOTS = 20,
    parameter logic [MASK_W-1:0] ERR_CODE = 16'h6400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [RAND_W-1:0] rand_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              tick_i,
    input  logic              abort_i,
    output logic              go_o,
    output logic              busy_o,
    output logic              mask_vld_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              err_o,
    output logic [MASK_W-1:0] err_code_o,
    output logic              spurious_o
);
    localparam int TICK_W = RAND_W + SLOT_LG;
    localparam int CNT_W  = LO_W + 1;

    logic [MASK_W-1:0] upd;
    logic              ovf;
    logic [TICK_W-1:0] ticks;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              expire;

    bkoff_calc #(
        .MASK_W(MASK_W), .RAND_W(RAND_W), .CHAN_W(CHAN_W),
        .SLOT_LG(SLOT_LG), .FIRST_SLOTS(FIRST_SLOTS)
    ) u_calc (
        .mask_i(mask_i), .rand_i(rand_i), .chan_i(chan_i),
        .upd_o(upd), .ovf_o(ovf), .ticks_o(ticks)
    );

    bkoff_seq #(
        .MASK_W(MASK_W), .TICK_W(TICK_W), .LO_W(LO_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .ovf_i(ovf), .upd_i(upd), .ticks_i(ticks), .expire_i(expire),
        .ld_o(ld), .ld_val_o(ld_val), .go_o(go_o), .busy_o(busy_o),
        .err_o(err_o), .mask_vld_o(mask_vld_o), .mask_o(mask_o),
        .spurious_o(spurious_o)
    );

    bkoff_timer #(.LO_W(LO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_val_i(ld_val),
        .tick_i(tick_i), .expire_o(expire)
    );

    // Completion code is driven only while the error strobe is up.
    assign err_code_o = err_o ? ERR_CODE : '0;
endmodule

// File: rtl/bkoff_sched_chk.sv
// bkoff_sched_chk: port-level properties of the backoff scheduler.
// Bound to every bkoff_sched instance; uses the default widths.
module bkoff_sched_chk #(
    parameter int MASK_W = 16,
    parameter logic [MASK_W-1:0] ERR_CODE = 16'h6400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              abort_i,
    input logic [MASK_W-1:0] mask_i,
    input logic              go_o,
    input logic              busy_o,
    input logic              mask_vld_o,
    input logic [MASK_W-1:0] mask_o,
    input logic              err_o,
    input logic [MASK_W-1:0] err_code_o,
    input logic              spurious_o
);
    AST_MASK_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !abort_i) |=> (mask_vld_o && (mask_o == (($past(mask_i) << 1) | MASK_W'(1))))); // R2
    AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o == ERR_CODE && mask_o[MASK_W-1] && !go_o && !busy_o)); // R3
    AST_GO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> ($past(busy_o) || $past(start_i))); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !mask_vld_o); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !go_o && !mask_vld_o)); // R9
    AST_SPUR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spurious_o |=> spurious_o); // R10
endmodule

bind bkoff_sched bkoff_sched_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .mask_i(mask_i), .go_o(go_o), .busy_o(busy_o), .mask_vld_o(mask_vld_o),
    .mask_o(mask_o), .err_o(err_o), .err_code_o(err_code_o),
    .spurious_o(spurious_o)
);

// File: tb/bkoff_sched_tb.sv
// bkoff_sched_tb: sweeps every retry mask width with several random and
// channel values, and counts delivered ticks up to the enable pulse.
module bkoff_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [9:0]  rand_i = '0;
    logic [3:0]  chan_i = '0;
    logic        tick_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        go_o, busy_o, mask_vld_o, err_o, spurious_o;
    logic [15:0] mask_o, err_code_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bkoff_sched u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .rand_i(rand_i), .chan_i(chan_i), .tick_i(tick_i), .abort_i(abort_i),
        .go_o(go_o), .busy_o(busy_o), .mask_vld_o(mask_vld_o), .mask_o(mask_o),
        .err_o(err_o), .err_code_o(err_code_o), .spurious_o(spurious_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_slots(input logic [15:0] m, input logic [9:0] r,
                                     input logic [3:0] c);
        logic [15:0] nm;
        logic [9:0]  s;
        nm = (m << 1) | 16'h0001;
        if (nm == 16'h0001) return 20;
        s = (r ^ {6'b0, c}) & nm[10:1];
        return int'(s);
    endfunction

    // One attempt: start, check mask/error, then count ticks to go_o.
    task automatic attempt(input logic [15:0] m, input logic [9:0] r,
                           input logic [3:0] c, input int gap, input string req);
        logic [15:0] nm;
        int slots, n, k;
        nm    = (m << 1) | 16'h0001;
        slots = exp_slots(m, r, c);
        @(negedge clk);
        start_i = 1'b1; mask_i = m; rand_i = r; chan_i = c; tick_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(mask_vld_o == 1'b1, "R2", "mask_vld", mask_vld_o, 1);
        chk(mask_o == nm, "R2", "mask_o", mask_o, nm);
        if (nm[15]) begin
            chk(err_o && err_code_o == 16'h6400 && !go_o && !busy_o, "R3", "overflow code",
                err_code_o, 16'h6400);
        end else if (slots == 0) begin
            chk(go_o && !busy_o && err_code_o == 16'h0, "R6", "immediate go", go_o, 1);
        end else begin
            chk(busy_o && !go_o && err_code_o == 16'h0, req, "busy at start", busy_o, 1);
            n = 0; k = 0;
            while (!go_o && k < 20000) begin
                tick_i = ((k % gap) == 0);
                @(negedge clk);
                if (tick_i) n++;
                k++;
            end
            tick_i = 1'b0;
            chk(go_o && n == 8 * slots, req, "ticks to go", n, 8 * slots);
        end
        @(negedge clk);
        chk(!go_o && !busy_o && !mask_vld_o && !err_o, req, "strobes drop", go_o, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!go_o && !busy_o && !mask_vld_o && !err_o && !spurious_o
            && mask_o == 16'h0 && err_code_o == 16'h0, "R1", "reset state", mask_o, 0);

        // R4: first attempt, including the input mask whose top bit shifts out.
        attempt(16'h0000, 10'h3FF, 4'h0, 1, "R4");
        attempt(16'h8000, 10'h155, 4'h7, 2, "R4");

        // R5 R7 R11 sweep over every mask width.
        for (int lvl = 1; lvl <= 15; lvl++) begin
            logic [15:0] m;
            int gap;
            m   = (16'h0001 << lvl) - 16'h0001;
            gap = (lvl < 5) ? 3 : 1;
            attempt(m, 10'h3FF, 4'h0, gap, "R5");
            attempt(m, 10'h2AA, 4'h5, gap, "R11");
            attempt(m, 10'(lvl * 37), 4'(lvl), 1, "R7");
        end

        // R3: overflow cases.
        attempt(16'h4000, 10'h0, 4'h0, 1, "R3");
        attempt(16'hFFFF, 10'h0, 4'h0, 1, "R3");

        // R6: zero slots, including the channel XOR cancelling the random bit.
        attempt(16'h0001, 10'h002, 4'h0, 1, "R6");
        attempt(16'h0003, 10'h001, 4'h1, 1, "R6");

        // R8: start during a wait is ignored.
        begin
            int n;
            @(negedge clk);
            start_i = 1'b1; mask_i = 16'h0000;
            @(negedge clk);
            start_i = 1'b0;
            n = 0;
            for (int i = 0; i < 10; i++) begin
                tick_i = 1'b1; @(negedge clk); n++;
            end
            tick_i = 1'b1; start_i = 1'b1; mask_i = 16'h00FF;
            @(negedge clk); n++;
            start_i = 1'b0;
            chk(!mask_vld_o && mask_o == 16'h0001 && busy_o, "R8", "start ignored", mask_o, 1);
            while (!go_o && n < 400) begin
                tick_i = 1'b1; @(negedge clk); n++;
            end
            tick_i = 1'b0;
            chk(go_o && n == 160, "R8", "wait unchanged", n, 160);
            @(negedge clk);
        end

        // R9 R10: abort mid-wait, then the stale segment expires.
        begin
            bit saw_go;
            @(negedge clk);
            start_i = 1'b1; mask_i = 16'h0000;
            @(negedge clk);
            start_i = 1'b0;
            for (int i = 0; i < 50; i++) begin
                tick_i = 1'b1; @(negedge clk);
            end
            tick_i = 1'b0; abort_i = 1'b1;
            @(negedge clk);
            abort_i = 1'b0;
            chk(!busy_o && !go_o, "R9", "abort clears busy", busy_o, 0);
            chk(!spurious_o, "R10", "flag clear before expiry", spurious_o, 0);
            saw_go = 1'b0;
            for (int i = 0; i < 64; i++) begin
                tick_i = 1'b1; @(negedge clk);
                if (go_o) saw_go = 1'b1;
            end
            tick_i = 1'b0;
            chk(!saw_go, "R9", "no go after abort", saw_go, 0);
            chk(spurious_o, "R10", "stale expiry flagged", spurious_o, 1);
            repeat (3) @(negedge clk);
            chk(spurious_o, "R10", "flag sticky", spurious_o, 1);

            // R9: abort and start in the same cycle.
            start_i = 1'b1; abort_i = 1'b1; mask_i = 16'h0003;
            @(negedge clk);
            start_i = 1'b0; abort_i = 1'b0;
            chk(!mask_vld_o && !busy_o && mask_o == 16'h0001, "R9", "abort beats start",
                mask_o, 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule